// File: doc/BRIEF.md
# PCI Configuration Forwarding Decoder

This block sits behind the upstream port of a PCI-to-PCI bridge. When a configuration request addressed through the hierarchical (Type 1) format arrives, the block inspects the address phase and decides what the bridge should do with it. The request can be turned into a Type 0 access on the secondary bus, passed along untouched to a deeper bridge, turned into a special cycle, or left alone. It reads the command, the 32-bit address word and the bridge's two bus-number registers (secondary and subordinate), and samples them on an address-phase strobe.

For a Type 0 conversion the block builds the downstream address word. The device number is replaced by a one-hot device-select field in the upper half of the word. The function and register fields are kept. The block also flags a conversion that is expected to end in a master abort because no device-select line is driven. It marks a conversion as a delayed, single-word transfer and reports a request for more than one data phase. All results are registered and appear together with a one-cycle valid pulse.

Top module: `cfgFwdDecode`

## Requirements
- R1: A request is decoded only when the command is configuration read (4'b1010) or configuration write (4'b1011) and address bits [1:0] are 2'b01. Any other request gives outcome 2'b00 (ignore) with a zero address word and all flags low.
- R2: The outcome code is 2'b00 ignore, 2'b01 Type 0 conversion, 2'b10 Type 1 forward and 2'b11 special cycle. On the clock edge that samples the strobe, all outputs are loaded and decodeValid is high for exactly that one following cycle. The outputs then hold until the next strobe.
- R3: When the bus number in address bits [23:16] is greater than secBus and at most subBus, the outcome is Type 1 forward and downAddr equals the incoming address word unchanged.
- R4: When the bus number equals secBus and the device number in bits [15:11] is 0 to 15, the outcome is Type 0. downAddr[31:16] has only bit 16+n set, bits [15:11] are zero and bits [1:0] are 2'b00.
- R5: In a Type 0 conversion, the function field [10:8] and the register field [7:2] are copied to downAddr unmodified.
- R6: Device numbers 16 to 30 with bus equal to secBus still produce a Type 0 conversion, with downAddr[31:16] all zero.
- R7: Device number 31 with bus equal to secBus and a non-zero register field gives a special cycle: downAddr equals the incoming word and all flags are low. With a zero register field it gives a Type 0 conversion with no device-select bit.
- R8: expectAbort is high exactly when the outcome is Type 0 and downAddr[31:16] is zero.
- R9: delayedTxn is high on every Type 0 conversion. burstExceeded is high when the outcome is Type 0 and burstReq was high at the strobe. Both are low for every other outcome.
- R10: A bus number below secBus or above subBus gives the ignore outcome, a zero address word and all flags low.
- R11: A synchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addrStrobe | input | 1 | Address phase valid; inputs sampled on this cycle |
| adWord | input | 32 | Address word of the upstream configuration request |
| cmdCode | input | 4 | Bus command of the request |
| burstReq | input | 1 | Request asks for more than one data phase |
| secBus | input | 8 | Secondary bus number register |
| subBus | input | 8 | Subordinate bus number register |
| decodeValid | output | 1 | One-cycle pulse: new decode result present |
| outcome | output | 2 | Decode result code |
| downAddr | output | 32 | Downstream address word |
| expectAbort | output | 1 | Type 0 access with no device-select line driven |
| delayedTxn | output | 1 | Conversion handled as a delayed single-word transfer |
| burstExceeded | output | 1 | Conversion asked for more than one data phase |

## Verification
Every result is due one clock edge after the edge that samples addrStrobe. The bench drives the strobe on a falling edge and reads all outputs on the next falling edge, so each read falls half a period after the registers load. One falling edge later it reads again, with the strobe low. There it expects decodeValid low and every other output unchanged, which covers the hold rule. Reset is checked the same way, on the falling edge after a reset edge.

// File: rtl/cfgFwdPkg.sv
package cfgFwdPkg;

  localparam int ADDR_W    = 32;
  localparam int BUS_W     = 8;
  localparam int DEV_W     = 5;
  localparam int REG_W     = 6;
  localparam int SEL_LSB   = 16;

  typedef enum logic [1:0] {
    FWD_IGNORE  = 2'b00,
    FWD_TYPE0   = 2'b01,
    FWD_TYPE1   = 2'b10,
    FWD_SPECIAL = 2'b11
  } fwdKind_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  typedef struct packed {
    logic     load;
    fwdKind_e kind;
    logic     burst;
  } ctrlStrobes_t;

endpackage

// File: rtl/cfgFwdCtrl.sv
module cfgFwdCtrl
  import cfgFwdPkg::*;
#(
  parameter int BUS_BITS = BUS_W,
  parameter int DEV_BITS = DEV_W,
  parameter int REG_BITS = REG_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                addrStrobe,
  input  logic [3:0]          cmdCode,
  input  logic [1:0]          typeBits,
  input  logic                burstReq,
  input  logic [BUS_BITS-1:0] busNum,
  input  logic [DEV_BITS-1:0] devNum,
  input  logic [REG_BITS-1:0] regNum,
  input  logic [BUS_BITS-1:0] secBus,
  input  logic [BUS_BITS-1:0] subBus,
  output ctrlStrobes_t        ctl,
  output logic                decodeValid,
  output fwdKind_e            outcome
);

  localparam logic [DEV_BITS-1:0] DEV_BCAST = {DEV_BITS{1'b1}};

  logic     isCfgCmd;
  logic     isHier;
  logic     onSecondary;
  logic     inWindow;
  fwdKind_e nextKind;

  always_comb begin
    isCfgCmd    = (cmdCode == CMD_CFG_RD) || (cmdCode == CMD_CFG_WR);
    isHier      = isCfgCmd && (typeBits == 2'b01);
    onSecondary = (busNum == secBus);
    inWindow    = (busNum > secBus) && (busNum <= subBus);
    nextKind    = FWD_IGNORE;
    if (isHier) begin
      if (onSecondary) begin
        if ((devNum == DEV_BCAST) && (regNum != '0)) nextKind = FWD_SPECIAL;
        else                                          nextKind = FWD_TYPE0;
      end else if (inWindow) begin
        nextKind = FWD_TYPE1;
      end
    end
  end

  always_comb begin
    ctl.load  = addrStrobe;
    ctl.kind  = nextKind;
    ctl.burst = burstReq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decodeValid <= 1'b0;
      outcome     <= FWD_IGNORE;
    end else begin
      decodeValid <= addrStrobe;
      if (addrStrobe) outcome <= nextKind;
    end
  end

  // R2: valid follows the strobe by one edge
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    addrStrobe |=> decodeValid);
  p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
    !addrStrobe |=> !decodeValid);
  // R2: result holds between strobes
  p_outcome_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !addrStrobe |=> $stable(outcome));
  // R1: a non-configuration command never yields a decode
  p_cmd_gate_r1: assert property (@(posedge clk) disable iff (rst)
    (addrStrobe && cmdCode[3:1] != 3'b101) |=> (outcome == FWD_IGNORE));

endmodule

// File: rtl/cfgFwdData.sv
module cfgFwdData
  import cfgFwdPkg::*;
#(
  parameter int AW      = ADDR_W,
  parameter int DEV_BITS = DEV_W,
  parameter int SEL_BASE = SEL_LSB
) (
  input  logic         clk,
  input  logic         rst,
  input  ctrlStrobes_t ctl,
  input  logic [AW-1:0] adWord,
  output logic [AW-1:0] downAddr,
  output logic         expectAbort,
  output logic         delayedTxn,
  output logic         burstExceeded
);

  localparam int SEL_N   = AW - SEL_BASE;
  localparam int DEV_LSB = 11;
  localparam int GAP_W   = SEL_BASE - DEV_LSB;
  localparam int KEEP_W  = DEV_LSB - 2;

  logic [SEL_N-1:0]   selVec;
  logic [DEV_BITS-1:0] devField;
  logic [AW-1:0]      type0Addr;
  logic [AW-1:0]      nextAddr;
  logic               nextAbort;
  logic               nextDelayed;
  logic               nextBurst;

  assign devField = adWord[DEV_LSB +: DEV_BITS];

  genvar gi;
  generate
    for (gi = 0; gi < SEL_N; gi++) begin : g_sel
      if (gi < (1 << DEV_BITS)) begin : g_hit
        assign selVec[gi] = (devField == DEV_BITS'(gi));
      end else begin : g_none
        assign selVec[gi] = 1'b0;
      end
    end
  endgenerate

  assign type0Addr = {selVec, {GAP_W{1'b0}}, adWord[2 +: KEEP_W], 2'b00};

  always_comb begin
    nextAddr    = '0;
    nextAbort   = 1'b0;
    nextDelayed = 1'b0;
    nextBurst   = 1'b0;
    unique case (ctl.kind)
      FWD_TYPE0: begin
        nextAddr    = type0Addr;
        nextAbort   = (selVec == '0);
        nextDelayed = 1'b1;
        nextBurst   = ctl.burst;
      end
      FWD_TYPE1, FWD_SPECIAL: nextAddr = adWord;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      downAddr      <= '0;
      expectAbort   <= 1'b0;
      delayedTxn    <= 1'b0;
      burstExceeded <= 1'b0;
    end else if (ctl.load) begin
      downAddr      <= nextAddr;
      expectAbort   <= nextAbort;
      delayedTxn    <= nextDelayed;
      burstExceeded <= nextBurst;
    end
  end

  // R4: at most one device-select line on a conversion
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    delayedTxn |-> $onehot0(downAddr[AW-1:SEL_BASE]));
  // R4: converted word has a zero type field
  p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
    delayedTxn |-> (downAddr[1:0] == 2'b00));
  // R8: abort flag only with an empty select field
  p_abort_empty_r8: assert property (@(posedge clk) disable iff (rst)
    expectAbort |-> (delayedTxn && downAddr[AW-1:SEL_BASE] == '0));
  // R9: burst flag implies a delayed conversion
  p_burst_conv_r9: assert property (@(posedge clk) disable iff (rst)
    burstExceeded |-> delayedTxn);

endmodule

// File: rtl/cfgFwdDecode.sv
module cfgFwdDecode
  import cfgFwdPkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int BUS_BITS = BUS_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                addrStrobe,
  input  logic [AW-1:0]       adWord,
  input  logic [3:0]          cmdCode,
  input  logic                burstReq,
  input  logic [BUS_BITS-1:0] secBus,
  input  logic [BUS_BITS-1:0] subBus,
  output logic                decodeValid,
  output logic [1:0]          outcome,
  output logic [AW-1:0]       downAddr,
  output logic                expectAbort,
  output logic                delayedTxn,
  output logic                burstExceeded
);

  ctrlStrobes_t ctl;
  fwdKind_e     outcomeQ;

  cfgFwdCtrl #(.BUS_BITS(BUS_BITS), .DEV_BITS(DEV_W), .REG_BITS(REG_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .addrStrobe (addrStrobe),
    .cmdCode    (cmdCode),
    .typeBits   (adWord[1:0]),
    .burstReq   (burstReq),
    .busNum     (adWord[16 +: BUS_BITS]),
    .devNum     (adWord[11 +: DEV_W]),
    .regNum     (adWord[2 +: REG_W]),
    .secBus     (secBus),
    .subBus     (subBus),
    .ctl        (ctl),
    .decodeValid(decodeValid),
    .outcome    (outcomeQ)
  );

  cfgFwdData #(.AW(AW), .DEV_BITS(DEV_W), .SEL_BASE(SEL_LSB)) u_data (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .adWord       (adWord),
    .downAddr     (downAddr),
    .expectAbort  (expectAbort),
    .delayedTxn   (delayedTxn),
    .burstExceeded(burstExceeded)
  );

  assign outcome = outcomeQ;

  // R8: abort flag and outcome agree across control and datapath
  p_abort_kind_r8: assert property (@(posedge clk) disable iff (rst)
    expectAbort |-> (outcomeQ == FWD_TYPE0));
  // R9: delayed marking only on conversions
  p_delayed_kind_r9: assert property (@(posedge clk) disable iff (rst)
    delayedTxn == (outcomeQ == FWD_TYPE0));
  // R10: ignore outcome leaves the address word clear
  p_ignore_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (outcomeQ == FWD_IGNORE) |-> (downAddr == '0 && !expectAbort));

endmodule

// File: tb/sim_cfgFwdDecode.sv
module sim_cfgFwdDecode;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addrStrobe = 1'b0;
  logic [31:0] adWord = '0;
  logic [3:0]  cmdCode = '0;
  logic        burstReq = 1'b0;
  logic [7:0]  secBus = '0;
  logic [7:0]  subBus = '0;
  logic        decodeValid;
  logic [1:0]  outcome;
  logic [31:0] downAddr;
  logic        expectAbort;
  logic        delayedTxn;
  logic        burstExceeded;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgFwdDecode u0 (
    .clk(clk), .rst(rst), .addrStrobe(addrStrobe), .adWord(adWord),
    .cmdCode(cmdCode), .burstReq(burstReq), .secBus(secBus), .subBus(subBus),
    .decodeValid(decodeValid), .outcome(outcome), .downAddr(downAddr),
    .expectAbort(expectAbort), .delayedTxn(delayedTxn), .burstExceeded(burstExceeded)
  );

  localparam logic [3:0] RD = 4'b1010;
  localparam logic [3:0] WR = 4'b1011;

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input logic [7:0] bus, input logic [4:0] dev,
                                         input logic [2:0] fn, input logic [5:0] rg,
                                         input logic [1:0] ty);
    return {8'h00, bus, dev, fn, rg, ty};
  endfunction

  // expected results straight from the requirements
  task automatic expect_of(input logic [31:0] ad, input logic [3:0] cmd, input logic brst,
                           input logic [7:0] sb, input logic [7:0] ub,
                           output logic [1:0] oc, output logic [31:0] da,
                           output logic ab, output logic dl, output logic bx);
    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [15:0] sel;
    bus = ad[23:16];
    dev = ad[15:11];
    oc = 2'b00; da = '0; ab = 1'b0; dl = 1'b0; bx = 1'b0;
    if ((cmd == RD || cmd == WR) && ad[1:0] == 2'b01) begin
      if (bus == sb) begin
        if (dev == 5'h1F && ad[7:2] != 6'd0) begin
          oc = 2'b11; da = ad;
        end else begin
          sel = (dev < 5'd16) ? (16'h0001 << dev) : 16'h0000;
          oc = 2'b01;
          da = {sel, 5'b0, ad[10:2], 2'b00};
          ab = (sel == 16'h0000);
          dl = 1'b1;
          bx = brst;
        end
      end else if (bus > sb && bus <= ub) begin
        oc = 2'b10; da = ad;
      end
    end
  endtask

  task automatic runCase(input string tag, input logic [31:0] ad, input logic [3:0] cmd,
                         input logic brst, input logic [7:0] sb, input logic [7:0] ub);
    logic [1:0] eOc; logic [31:0] eDa; logic eAb, eDl, eBx;
    expect_of(ad, cmd, brst, sb, ub, eOc, eDa, eAb, eDl, eBx);
    @(negedge clk);
    adWord = ad; cmdCode = cmd; burstReq = brst; secBus = sb; subBus = ub;
    addrStrobe = 1'b1;
    @(negedge clk);
    addrStrobe = 1'b0;
    check(tag, "valid", 32'(decodeValid), 32'd1);
    check(tag, "outcome", 32'(outcome), 32'(eOc));
    check(tag, "downAddr", downAddr, eDa);
    check(tag, "expectAbort", 32'(expectAbort), 32'(eAb));
    check(tag, "delayedTxn", 32'(delayedTxn), 32'(eDl));
    check(tag, "burstExceeded", 32'(burstExceeded), 32'(eBx));
    adWord = ~ad; cmdCode = RD; burstReq = ~brst;
    @(negedge clk);
    check("R2", "valid pulse ends", 32'(decodeValid), 32'd0);
    check("R2", "outcome held", 32'(outcome), 32'(eOc));
    check("R2", "downAddr held", downAddr, eDa);
  endtask

  task automatic checkAllZero(input string tag);
    check(tag, "valid", 32'(decodeValid), 0);
    check(tag, "outcome", 32'(outcome), 0);
    check(tag, "downAddr", downAddr, 0);
    check(tag, "flags", {29'd0, expectAbort, delayedTxn, burstExceeded}, 0);
  endtask

  task automatic testReset();
    checkAllZero("R11");
  endtask

  task automatic testForward();
    runCase("R3", mkAddr(8'h05, 5'd3, 3'd2, 6'h11, 2'b01), RD, 1'b0, 8'h04, 8'h09);
    runCase("R3", mkAddr(8'h09, 5'd0, 3'd0, 6'h00, 2'b01), WR, 1'b1, 8'h04, 8'h09);
    runCase("R3", {8'hA5, 8'h07, 16'hBEEF & 16'hFFFD}, WR, 1'b0, 8'h04, 8'h09);
  endtask

  task automatic testType0();
    runCase("R4", mkAddr(8'h04, 5'd0,  3'd0, 6'h00, 2'b01), RD, 1'b0, 8'h04, 8'h09);
    runCase("R4", mkAddr(8'h04, 5'd7,  3'd5, 6'h2A, 2'b01), WR, 1'b0, 8'h04, 8'h09);
    runCase("R5", mkAddr(8'h04, 5'd15, 3'd7, 6'h3F, 2'b01), RD, 1'b0, 8'h04, 8'h09);
    runCase("R5", {8'hFF, 8'h04, 5'd9, 3'd3, 6'h15, 2'b01}, WR, 1'b0, 8'h04, 8'h09);
  endtask

  task automatic testHighDev();
    runCase("R6", mkAddr(8'h04, 5'd16, 3'd1, 6'h04, 2'b01), RD, 1'b0, 8'h04, 8'h09);
    runCase("R6", mkAddr(8'h04, 5'd30, 3'd6, 6'h10, 2'b01), WR, 1'b0, 8'h04, 8'h09);
  endtask

  task automatic testDevAllOnes();
    runCase("R7", mkAddr(8'h04, 5'd31, 3'd7, 6'h01, 2'b01), WR, 1'b1, 8'h04, 8'h09);
    runCase("R7", mkAddr(8'h04, 5'd31, 3'd7, 6'h00, 2'b01), WR, 1'b0, 8'h04, 8'h09);
    runCase("R8", mkAddr(8'h04, 5'd31, 3'd0, 6'h00, 2'b01), RD, 1'b0, 8'h04, 8'h09);
  endtask

  task automatic testBurst();
    runCase("R9", mkAddr(8'h04, 5'd2, 3'd0, 6'h08, 2'b01), RD, 1'b1, 8'h04, 8'h09);
    runCase("R9", mkAddr(8'h06, 5'd2, 3'd0, 6'h08, 2'b01), RD, 1'b1, 8'h04, 8'h09);
  endtask

  task automatic testOutside();
    runCase("R10", mkAddr(8'h03, 5'd1, 3'd0, 6'h02, 2'b01), RD, 1'b1, 8'h04, 8'h09);
    runCase("R10", mkAddr(8'h0A, 5'd1, 3'd0, 6'h02, 2'b01), WR, 1'b1, 8'h04, 8'h09);
    runCase("R10", mkAddr(8'h05, 5'd1, 3'd0, 6'h02, 2'b01), WR, 1'b0, 8'h04, 8'h04);
  endtask

  task automatic testRecognise();
    runCase("R1", mkAddr(8'h04, 5'd1, 3'd0, 6'h02, 2'b00), RD, 1'b0, 8'h04, 8'h09);
    runCase("R1", mkAddr(8'h05, 5'd1, 3'd0, 6'h02, 2'b11), WR, 1'b0, 8'h04, 8'h09);
    runCase("R1", mkAddr(8'h04, 5'd1, 3'd0, 6'h02, 2'b01), 4'b0110, 1'b0, 8'h04, 8'h09);
    runCase("R1", mkAddr(8'h05, 5'd1, 3'd0, 6'h02, 2'b01), 4'b0111, 1'b0, 8'h04, 8'h09);
  endtask

  task automatic testMidReset();
    runCase("R2", mkAddr(8'h04, 5'd4, 3'd1, 6'h05, 2'b01), RD, 1'b1, 8'h04, 8'h09);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkAllZero("R11");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rst = 1'b0;
    testForward();
    testType0();
    testHighDev();
    testDevAllOnes();
    testBurst();
    testOutside();
    testRecognise();
    testMidReset();
    finishRun();
  end

endmodule